// File: doc/BRIEF.md
# Chien Search Error Locator

This block finds the roots of an error-locator polynomial over GF(2^13) and reports them as bit positions inside a data sector. Software writes up to 25 polynomial coefficients and a configuration word. It then starts the search by writing the number of bit positions to scan. The engine tests one candidate index per clock. For each index k it forms the sum of sigma_j·alpha^(j·k) and records k whenever that sum is zero.

When the scan ends, the engine raises a done flag and reports how many roots it found. It also flags the result as uncorrectable when the root count differs from the polynomial degree. Position registers hold the roots in ascending order as 1-based bit indices. Software then flips bit (index−1) mod 8 of byte (index−1)/8. The host side is a plain word-addressed register port with a combinational read path.

Top module: `chien_locator`

## Requirements
- R1: After reset the status word (address 0x03), the configuration word and every position register read 0.
- R2: The configuration word at address 0x00 keeps bits 20:16 as the coefficient count minus one (the degree d) and bit 0 as the sector flag (1 = 1024-byte sector, 0 = 512-byte sector). All other bits read back as 0.
- R3: A write to address 0x01 starts a search over indices 1..L, where L is wdata[15:0] after clamping. The done bit becomes visible L+1 clock edges after the edge that takes the start write, and the busy bit is set until then.
- R4: Index k is a root when the XOR over j = 0..d of sigma_j·alpha^(j·k) equals 0. The field uses the primitive polynomial x^13+x^4+x^3+x+1 with alpha = 2, and sigma_j is written at address 0x20+j. Coefficients with j > d have no effect.
- R5: Roots are stored as 1-based indices at addresses 0x40+i, in ascending order, and at most 24 are kept. A start clears all of them to 0. The root count saturates at 31.
- R6: The status word carries done in bit 0, busy in bit 1, the mismatch flag in bit 2 and the root count in bits 12:8. A read of the status word clears done.
- R7: After a search completes, the mismatch bit reads 1 exactly when the root count differs from d. A new start or a stop clears it.
- R8: Writing 1 to bit 0 of address 0x02 ends a running search at once, with busy, done and mismatch reading 0 afterwards.
- R9: If a status read falls in the same cycle as the search completion, done is still set afterwards. That read itself returns done = 0 and busy = 1.
- R10: The clamp limit for L is 512·8 + 13·24 = 4408 with the sector flag at 0. With the flag at 1 it is 8191, the number of nonzero field elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (only status reads have a side effect) |
| addr | input | 7 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |

## Verification
Two events can meet in one cycle: the status read that clears done, and the completion of the scan that sets it. The bench issues a start and counts exactly L negative edges. It then places a status read on the completing edge. It requires that read to see busy high with done low, and the next read to see done high with the right count. A third read must see done low again, which shows that the clear on read still works.

// File: rtl/chien_pkg.sv
package chien_pkg;

  localparam int GF_M_DEF = 13;
  localparam logic [15:0] GF_POLY_DEF = 16'h001B;

  localparam int A_CFG    = 'h00;
  localparam int A_START  = 'h01;
  localparam int A_STOP   = 'h02;
  localparam int A_STATUS = 'h03;
  localparam int A_COEF   = 'h20;
  localparam int A_POS    = 'h40;

  // multiply a field element by alpha (shift and reduce)
  function automatic logic [15:0] gf_xtime(input logic [15:0] x, input int m,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = x << 1;
    if (x[m-1]) r = r ^ poly;
    return r & ((16'd1 << m) - 16'd1);
  endfunction

  // multiply a field element by alpha^j, j a small constant
  function automatic logic [15:0] gf_mul_apow(input logic [15:0] x, input int j,
                                              input int m, input logic [15:0] poly);
    logic [15:0] r;
    r = x;
    for (int i = 0; i < 32; i++) begin
      if (i < j) r = gf_xtime(r, m, poly);
    end
    return r;
  endfunction

endpackage

// File: rtl/chien_term.sv
module chien_term
  import chien_pkg::*;
#(
  parameter int          M    = GF_M_DEF,
  parameter logic [15:0] POLY = GF_POLY_DEF,
  parameter int          J    = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [M-1:0] coef_in,
  output logic [M-1:0] term_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    term_q <= '0;
    else if (load) term_q <= coef_in;
    else if (step) term_q <= M'(gf_mul_apow(16'(term_q), J, M, POLY));
  end

endmodule

// File: rtl/chien_rootlog.sv
module chien_rootlog #(
  parameter int POS_W = 13,
  parameter int T_MAX = 24,
  parameter int CNT_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          hit,
  input  logic [POS_W-1:0]              hit_pos,
  output logic [CNT_W-1:0]              cnt,
  output logic [T_MAX-1:0][POS_W-1:0]   pos
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pos <= '0;
    end else if (clr) begin
      cnt <= '0;
      pos <= '0;
    end else if (hit) begin
      for (int i = 0; i < T_MAX; i++) begin
        if (cnt == CNT_W'(i)) pos[i] <= hit_pos;
      end
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/chien_locator.sv
module chien_locator
  import chien_pkg::*;
#(
  parameter int          M          = GF_M_DEF,
  parameter logic [15:0] POLY       = GF_POLY_DEF,
  parameter int          T_MAX      = 24,
  parameter int          SEC_BYTES  = 512,
  parameter int          ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam int NCOEF     = T_MAX + 1;
  localparam int CW        = $clog2(NCOEF);
  localparam int CNT_W     = 5;
  localparam int LEN_W     = M + 3;
  localparam int FIELD_N   = (1 << M) - 1;
  localparam int RAW_SMALL = SEC_BYTES * 8 + M * T_MAX;
  localparam int RAW_LARGE = SEC_BYTES * 16 + M * T_MAX;
  localparam int LIM_SMALL = (RAW_SMALL > FIELD_N) ? FIELD_N : RAW_SMALL;
  localparam int LIM_LARGE = (RAW_LARGE > FIELD_N) ? FIELD_N : RAW_LARGE;

  logic [M-1:0]     coef_q [NCOEF];
  logic [M-1:0]     term   [NCOEF];
  logic [CW-1:0]    cfg_n_q;
  logic             cfg_big_q;
  logic             busy_q, done_q, complete_q;
  logic [LEN_W-1:0] idx_q, len_q, len_in, lim;
  logic [M-1:0]     sum;
  logic [CNT_W-1:0] cnt;
  logic [T_MAX-1:0][M-1:0] pos;
  logic             start_wr, stop_wr, stat_rd, hit, finish, mismatch;
  logic             unused_bits;

  assign unused_bits = ^{wdata[31:21], wdata[15:M]};

  // named events for the checker
  assign start_wr = wr_en && (addr == ADDR_W'(A_START));
  assign stop_wr  = wr_en && (addr == ADDR_W'(A_STOP)) && wdata[0];
  assign stat_rd  = rd_en && (addr == ADDR_W'(A_STATUS));
  assign finish   = busy_q && (idx_q >= len_q);
  assign hit      = busy_q && !start_wr && (idx_q != '0) && (sum == '0);
  assign mismatch = complete_q && (cnt != CNT_W'(cfg_n_q));

  always_comb begin
    lim    = cfg_big_q ? LEN_W'(LIM_LARGE) : LEN_W'(LIM_SMALL);
    len_in = (LEN_W'(wdata[15:0]) > lim) ? lim : LEN_W'(wdata[15:0]);
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < NCOEF; j++) begin
      if (CW'(j) <= cfg_n_q) sum = sum ^ term[j];
    end
  end

  // coefficient registers and running terms, one per power
  for (genvar j = 0; j < NCOEF; j++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[j] <= '0;
      else if (wr_en && addr == ADDR_W'(A_COEF + j)) coef_q[j] <= wdata[M-1:0];
    end
    chien_term #(.M(M), .POLY(POLY), .J(j)) u_term (
      .clk(clk), .rst_n(rst_n), .load(start_wr), .step(busy_q),
      .coef_in(coef_q[j]), .term_q(term[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_n_q   <= '0;
      cfg_big_q <= 1'b0;
    end else if (wr_en && addr == ADDR_W'(A_CFG)) begin
      cfg_n_q   <= wdata[16 +: CW];
      cfg_big_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; complete_q <= 1'b0;
      idx_q  <= '0;   len_q  <= '0;
    end else if (start_wr) begin
      busy_q <= 1'b1; done_q <= 1'b0; complete_q <= 1'b0;
      idx_q  <= '0;   len_q  <= len_in;
    end else if (stop_wr) begin
      busy_q <= 1'b0; done_q <= 1'b0; complete_q <= 1'b0;
    end else begin
      if (finish) begin
        busy_q     <= 1'b0;
        complete_q <= 1'b1;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
      end
      if (finish)       done_q <= 1'b1;
      else if (stat_rd) done_q <= 1'b0;
    end
  end

  chien_rootlog #(.POS_W(M), .T_MAX(T_MAX), .CNT_W(CNT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(start_wr), .hit(hit),
    .hit_pos(idx_q[M-1:0]), .cnt(cnt), .pos(pos)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CFG))
      rdata = (32'(cfg_n_q) << 16) | 32'(cfg_big_q);
    if (addr == ADDR_W'(A_STATUS))
      rdata = (32'(cnt) << 8) | {29'd0, mismatch, busy_q, done_q};
    for (int j = 0; j < NCOEF; j++)
      if (addr == ADDR_W'(A_COEF + j)) rdata = 32'(coef_q[j]);
    for (int i = 0; i < T_MAX; i++)
      if (addr == ADDR_W'(A_POS + i)) rdata = 32'(pos[i]);
  end

endmodule

// File: rtl/chien_locator_chk.sv
module chien_locator_chk #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_q,
  input logic             done_q,
  input logic             finish,
  input logic             hit,
  input logic             stat_rd,
  input logic             stop_wr,
  input logic             start_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [LEN_W-1:0] idx_q,
  input logic [LEN_W-1:0] len_q
);

  a_r3_idx_within_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= len_q);

  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  a_r6_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !finish) |=> !done_q);

  a_r9_finish_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !start_wr && !stop_wr) |=> (done_q && !busy_q));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!busy_q && !done_q));

  a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

endmodule

bind chien_locator chien_locator_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .done_q(done_q), .finish(finish),
  .hit(hit), .stat_rd(stat_rd), .stop_wr(stop_wr), .start_wr(start_wr),
  .cnt(cnt), .idx_q(idx_q), .len_q(len_q)
);

// File: tb/tb_chien_locator.sv
`timescale 1ns/1ps
module tb_chien_locator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  int cycles = 0;
  int rt[24];
  int sig[25];

  always #2 clk = ~clk;

  chien_locator dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus tasks: entered and left just after a falling edge
  task automatic bus_wr(input int a, input int d);
    addr = 7'(a); wdata = 32'(d); wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output int d);
    addr = 7'(a); rd_en = 1'b1;
    #1 d = int'(rdata);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int gf_mul(input int a, input int b);
    int r = 0, x = a;
    for (int i = 0; i < 13; i++) begin
      if ((b >> i) & 1) r ^= x;
      x = x << 1;
      if (x & 'h2000) x ^= 'h201B;
    end
    return r;
  endfunction

  function automatic int apow(input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = gf_mul(r, 2);
    return r;
  endfunction

  // sigma(x) = product over roots of (x + alpha^k)
  task automatic build_sigma(input int nr);
    int nw[25];
    for (int j = 0; j < 25; j++) sig[j] = 0;
    sig[0] = 1;
    for (int r = 0; r < nr; r++) begin
      int a = apow(rt[r]);
      for (int j = 0; j < 25; j++)
        nw[j] = gf_mul(sig[j], a) ^ ((j > 0) ? sig[j-1] : 0);
      sig = nw;
    end
  endtask

  task automatic wait_done(output int st);
    st = 0;
    while ((st & 1) == 0) bus_rd('h03, st);
  endtask

  task automatic run_case(input int nr, input bit big, input int wlen, input int junk);
    int st, eff, lim, ne, d;
    build_sigma(nr);
    for (int j = 0; j < 25; j++) bus_wr('h20 + j, (j <= nr) ? sig[j] : junk);
    bus_wr('h00, (nr << 16) | int'(big));
    bus_wr('h01, wlen);
    wait_done(st);
    lim = big ? 8191 : 4408;
    eff = (wlen > lim) ? lim : wlen;
    ne = 0;
    for (int r = 0; r < nr; r++) if (rt[r] <= eff) ne++;
    chk(((st >> 8) & 31) == ne, "R4 root count", (st >> 8) & 31, ne);
    chk(((st >> 1) & 1) == 0, "R3 busy low at done", (st >> 1) & 1, 0);
    chk(((st >> 2) & 1) == int'(ne != nr), "R7 mismatch", (st >> 2) & 1, int'(ne != nr));
    for (int i = 0; i < ne; i++) begin
      bus_rd('h40 + i, d);
      chk(d == rt[i], "R5 position", d, rt[i]);
    end
    if (ne < 24) begin
      bus_rd('h40 + ne, d);
      chk(d == 0, "R5 unused slot", d, 0);
    end
  endtask

  initial begin
    int d, st;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    bus_rd('h03, d); chk(d == 0, "R1 status", d, 0);
    bus_rd('h00, d); chk(d == 0, "R1 cfg", d, 0);
    bus_rd('h40, d); chk(d == 0, "R1 pos", d, 0);

    bus_wr('h00, 32'hFFFF_FFFF);
    bus_rd('h00, d); chk(d == 'h001F_0001, "R2 cfg mask", d, 'h001F_0001);

    // root at index 1 and junk in unused coefficients (R4)
    rt[0] = 1; run_case(1, 1'b0, 4408, 'h1ABC);
    // root at exact end and one past end (R3)
    rt[0] = 100; rt[1] = 101; run_case(2, 1'b0, 100, 'h0777);
    // clamp limits (R10)
    rt[0] = 4408; rt[1] = 4409; run_case(2, 1'b0, 6000, 0);
    rt[0] = 5000; rt[1] = 8191; run_case(2, 1'b1, 9000, 'h0055);

    // random trials
    for (int t = 0; t < 6; t++) begin
      int nr = 1 + int'($urandom % 24);
      int wl = 300 + int'($urandom % 4000);
      int gap = wl / nr, p = 0;
      for (int r = 0; r < nr; r++) begin
        p = p + 1 + int'($urandom % gap);
        rt[r] = p;
      end
      run_case(nr, 1'($urandom % 2), wl, int'($urandom % 8192));
    end

    // all-zero polynomial: every index is a root (R5 saturation)
    for (int j = 0; j < 25; j++) bus_wr('h20 + j, 0);
    bus_wr('h00, 3 << 16);
    bus_wr('h01, 40);
    wait_done(st);
    chk(((st >> 8) & 31) == 31, "R5 count saturates", (st >> 8) & 31, 31);
    chk(((st >> 2) & 1) == 1, "R7 mismatch on saturation", (st >> 2) & 1, 1);
    bus_rd('h40 + 23, d); chk(d == 24, "R5 last kept slot", d, 24);
    bus_rd('h40, d); chk(d == 1, "R5 first slot", d, 1);

    // stop (R8)
    bus_wr('h01, 4000);
    repeat (50) @(negedge clk);
    bus_wr('h02, 1);
    bus_rd('h03, d); chk((d & 7) == 0, "R8 stopped idle", d & 7, 0);
    repeat (5) @(negedge clk);
    bus_rd('h03, d); chk((d & 7) == 0, "R8 stays idle", d & 7, 0);

    // completion and status read in one cycle (R9)
    rt[0] = 5; build_sigma(1);
    bus_wr('h20, sig[0]); bus_wr('h21, sig[1]);
    bus_wr('h00, 1 << 16);
    bus_wr('h01, 20);
    repeat (20) @(negedge clk);
    bus_rd('h03, d); chk((d & 3) == 2, "R9 colliding read sees busy", d & 3, 2);
    bus_rd('h03, d); chk((d & 3) == 1, "R9 done survives", d & 3, 1);
    chk(((d >> 8) & 31) == 1, "R9 count", (d >> 8) & 31, 1);
    bus_rd('h03, d); chk((d & 1) == 0, "R6 read clears done", d & 1, 0);
    chk(((d >> 2) & 1) == 0, "R7 match keeps mismatch low", (d >> 2) & 1, 0);

    finish_run();
  end

endmodule